// File: doc/BRIEF.md
# Card Response Manchester Symbol Encoder

This block turns a card's response frame into a serial load-modulation pattern, one modulation bit per clock tick. A host fills a small byte buffer through a write port, each byte carrying an optional supplied parity bit. It then picks the frame options and pulses `start`. Each transmitted symbol is 8 ticks long and is emitted most significant pattern bit first. The four symbol patterns are: modulated first half 0xF0 (logic one), modulated second half 0x0F (logic zero), unmodulated 0x00 (stop), and fully modulated 0xFF (collision).

A frame is built in this order: a fixed correction symbol (0x08), a start symbol 0xF0, then the data bits of each byte LSB first, each byte followed by its parity symbol, and finally a stop symbol. A collision option replaces every data and parity symbol with the full-period pattern. A short-answer option sends only four bits with no parity. When a frame is accepted, the block also computes and holds the air duration of the frame, measured up to the end of the last modulation.

Top module: `card_resp_encoder`

## Requirements
- R1: After reset, and at any time `busy` is low, `mod_out` is 0. After reset, `duration` is 0 and `busy` is 0.
- R2: A `start` sampled while idle launches a frame. The first tick appears in the next cycle, and one pattern bit follows per cycle, MSB first. The sequence is correction 0x08, start 0xF0, then for each byte its 8 data bits LSB first (0xF0 for a one, 0x0F for a zero) followed by a parity symbol, then stop 0x00.
- R3: With `par_sel`=0 the parity symbol encodes odd parity: a one when the byte holds an even number of ones. With `par_sel`=1 it encodes the `wr_par` bit that was stored with that byte.
- R4: With `coll_mode`=1 every data and parity symbol is 0xFF. The correction, start and stop symbols are unchanged.
- R5: With `short_mode`=1 the frame is correction, start, then bits 0..3 of the byte at address 0 LSB first, then stop. No parity is sent and `nbytes` has no effect.
- R6: `busy` rises in the cycle after an accepted start. It stays high for exactly 8·(9N+3) cycles for an N-byte frame, or 56 cycles for a short answer, and then falls.
- R7: In the cycle after an accepted start, `duration` becomes 8·(9N+1), or 40 for a short answer. It is reduced by 4 when the last data or parity symbol sent is 0xF0 (never in collision mode). It holds until the next accepted start.
- R8: A `start` pulse while `busy` is high is ignored. The running frame and `duration` are unaffected.
- R9: Buffer writes while `busy` is high are ignored. A later frame sends the buffer contents written before the frame began.
- R10: An `nbytes` value of 0 is treated as 1, and a value above MAX_BYTES is treated as MAX_BYTES.
- R11: `coll_mode`, `short_mode`, `par_sel` and `nbytes` are sampled only at an accepted start. Changing them mid-frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one modulation tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | ADDR_W (5) | Byte index to write |
| wr_data | input | 8 | Byte value |
| wr_par | input | 1 | Supplied parity bit stored with the byte |
| nbytes | input | LEN_W (6) | Number of bytes in the frame |
| par_sel | input | 1 | 0: odd parity, 1: supplied parity |
| coll_mode | input | 1 | Force data and parity symbols to 0xFF |
| short_mode | input | 1 | Send a 4-bit short answer |
| start | input | 1 | Launch a frame when idle |
| mod_out | output | 1 | Modulation bit for the current tick |
| busy | output | 1 | High while a frame is being sent |
| duration | output | DUR_W (12) | Air duration of the last accepted frame, in ticks |

## Verification
The bench builds the block with the default MAX_BYTES of 32. With that value, one frame can fill the whole buffer, 288 data and parity symbols. Because the 6-bit length port can carry 40, the clamp above the buffer size is also within reach, alongside the zero-length case. Each frame is compared tick by tick against a stream the bench builds from the symbol rules. The vectors cover both parity sources, collision mode, the short answer and both endings of the duration rule.

// File: rtl/card_enc_pkg.sv
`timescale 1ns/1ps
package card_enc_pkg;

  typedef enum logic [2:0] {
    SYM_NONE, SYM_CORR, SYM_D, SYM_E, SYM_F, SYM_COLL
  } sym_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CORR, PH_SOF, PH_DATA, PH_PAR, PH_EOF
  } phase_t;

  localparam int unsigned SYM_TICKS = 8;

  localparam logic [SYM_TICKS-1:0] PAT_CORR = 8'h08;
  localparam logic [SYM_TICKS-1:0] PAT_ONE  = 8'hF0;
  localparam logic [SYM_TICKS-1:0] PAT_ZERO = 8'h0F;
  localparam logic [SYM_TICKS-1:0] PAT_STOP = 8'h00;
  localparam logic [SYM_TICKS-1:0] PAT_COLL = 8'hFF;

  function automatic logic [SYM_TICKS-1:0] sym_pattern(sym_t s);
    case (s)
      SYM_CORR: sym_pattern = PAT_CORR;
      SYM_D:    sym_pattern = PAT_ONE;
      SYM_E:    sym_pattern = PAT_ZERO;
      SYM_COLL: sym_pattern = PAT_COLL;
      default:  sym_pattern = PAT_STOP;
    endcase
  endfunction

  function automatic logic odd_parity(logic [7:0] b);
    odd_parity = ~^b;
  endfunction

endpackage

// File: rtl/card_enc_store.sv
`timescale 1ns/1ps
module card_enc_store #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wr_par,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [7:0]        rd_byte_a,
  output logic              rd_par_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [7:0]        rd_byte_b,
  output logic              rd_par_b
);

  logic [8:0] entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[g] <= '0;
      end else if (hit) begin
        entry_q[g] <= {wr_par, wr_data};
      end
    end
  end

  always_comb begin
    rd_byte_a = entry_q[rd_addr_a][7:0];
    rd_par_a  = entry_q[rd_addr_a][8];
    rd_byte_b = entry_q[rd_addr_b][7:0];
    rd_par_b  = entry_q[rd_addr_b][8];
  end

endmodule

// File: rtl/card_enc_seq.sv
`timescale 1ns/1ps
module card_enc_seq
  import card_enc_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              coll_mode,
  input  logic              short_mode,
  input  logic              par_sel,
  input  logic [LEN_W-1:0]  len_eff,
  input  logic [7:0]        rd_byte,
  input  logic              rd_par,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              launch,
  output sym_t              sym,
  output logic [2:0]        tick
);

  phase_t            phase_q, phase_d;
  logic [2:0]        tick_q, tick_d;
  logic [2:0]        bit_q, bit_d;
  logic [ADDR_W-1:0] byte_q, byte_d, last_q, last_d;
  logic              coll_q, coll_d, short_q, short_d, psel_q, psel_d;
  logic              sym_end, par_bit;

  assign launch  = start && (phase_q == PH_IDLE);
  assign sym_end = (tick_q == 3'd7);
  assign par_bit = psel_q ? rd_par : odd_parity(rd_byte);

  always_comb begin
    phase_d = phase_q;
    tick_d  = tick_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    last_d  = last_q;
    coll_d  = coll_q;
    short_d = short_q;
    psel_d  = psel_q;
    if (launch) begin
      phase_d = PH_CORR;
      tick_d  = 3'd0;
      bit_d   = 3'd0;
      byte_d  = '0;
      last_d  = ADDR_W'(len_eff - LEN_W'(1));
      coll_d  = coll_mode;
      short_d = short_mode;
      psel_d  = par_sel;
    end else if (phase_q != PH_IDLE) begin
      tick_d = tick_q + 3'd1;
      if (sym_end) begin
        case (phase_q)
          PH_CORR: phase_d = PH_SOF;
          PH_SOF: begin
            phase_d = PH_DATA;
            bit_d   = 3'd0;
          end
          PH_DATA: begin
            if (short_q && (bit_q == 3'd3)) begin
              phase_d = PH_EOF;
            end else if (bit_q == 3'd7) begin
              phase_d = PH_PAR;
            end else begin
              bit_d = bit_q + 3'd1;
            end
          end
          PH_PAR: begin
            if (byte_q == last_q) begin
              phase_d = PH_EOF;
            end else begin
              phase_d = PH_DATA;
              byte_d  = byte_q + ADDR_W'(1);
              bit_d   = 3'd0;
            end
          end
          default: phase_d = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tick_q  <= 3'd0;
      bit_q   <= 3'd0;
      byte_q  <= '0;
      last_q  <= '0;
      coll_q  <= 1'b0;
      short_q <= 1'b0;
      psel_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tick_q  <= tick_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      last_q  <= last_d;
      coll_q  <= coll_d;
      short_q <= short_d;
      psel_q  <= psel_d;
    end
  end

  always_comb begin
    case (phase_q)
      PH_CORR: sym = SYM_CORR;
      PH_SOF:  sym = SYM_D;
      PH_DATA: sym = coll_q ? SYM_COLL : (rd_byte[bit_q] ? SYM_D : SYM_E);
      PH_PAR:  sym = coll_q ? SYM_COLL : (par_bit ? SYM_D : SYM_E);
      PH_EOF:  sym = SYM_F;
      default: sym = SYM_NONE;
    endcase
  end

  assign busy    = (phase_q != PH_IDLE);
  assign tick    = tick_q;
  assign rd_addr = byte_q;

  a_r2_launch_corr: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (phase_q == PH_CORR) && (tick_q == 3'd0));

  a_r6_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sym_end) |=> busy && (tick_q == $past(tick_q) + 3'd1));

  a_r5_short_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (short_q && (phase_q == PH_DATA)) |-> (bit_q <= 3'd3));

  a_r10_byte_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_DATA) || (phase_q == PH_PAR)) |-> (byte_q <= last_q));

  a_r8_start_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !sym_end) |=> (phase_q == $past(phase_q)));

endmodule

// File: rtl/card_enc_dur.sv
`timescale 1ns/1ps
module card_enc_dur
  import card_enc_pkg::*;
#(
  parameter int unsigned LEN_W = 6,
  parameter int unsigned DUR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             coll_mode,
  input  logic             short_mode,
  input  logic             par_sel,
  input  logic [LEN_W-1:0] len_eff,
  input  logic [7:0]       tail_byte,
  input  logic             tail_par,
  output logic [DUR_W-1:0] duration
);

  logic [DUR_W-1:0] dur_q, dur_d, base;
  logic             last_one;

  always_comb begin
    if (short_mode) begin
      base     = DUR_W'(SYM_TICKS * 5);
      last_one = tail_byte[3];
    end else begin
      base     = DUR_W'(len_eff) * DUR_W'(SYM_TICKS * 9) + DUR_W'(SYM_TICKS);
      last_one = par_sel ? tail_par : odd_parity(tail_byte);
    end
    dur_d = base - ((last_one && !coll_mode) ? DUR_W'(SYM_TICKS / 2) : DUR_W'(0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_q <= '0;
    end else if (load) begin
      dur_q <= dur_d;
    end
  end

  assign duration = dur_q;

  a_r7_short_value: assert property (@(posedge clk) disable iff (!rst_n)
    (load && short_mode) |=> ((dur_q == DUR_W'(40)) || (dur_q == DUR_W'(36))));

endmodule

// File: rtl/card_enc_shift.sv
`timescale 1ns/1ps
module card_enc_shift
  import card_enc_pkg::*;
(
  input  sym_t       sym,
  input  logic [2:0] tick,
  output logic       mod_out
);

  logic [SYM_TICKS-1:0] pat;

  always_comb begin
    pat     = sym_pattern(sym);
    mod_out = pat[3'd7 - tick];
  end

endmodule

// File: rtl/card_resp_encoder.sv
`timescale 1ns/1ps
module card_resp_encoder
  import card_enc_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 32,
  localparam int unsigned ADDR_W = $clog2(MAX_BYTES),
  localparam int unsigned LEN_W  = $clog2(MAX_BYTES + 1),
  localparam int unsigned DUR_W  = $clog2(SYM_TICKS * (9 * MAX_BYTES + 1) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wr_par,
  input  logic [LEN_W-1:0]  nbytes,
  input  logic              par_sel,
  input  logic              coll_mode,
  input  logic              short_mode,
  input  logic              start,
  output logic              mod_out,
  output logic              busy,
  output logic [DUR_W-1:0]  duration
);

  logic [LEN_W-1:0]  len_eff;
  logic [ADDR_W-1:0] seq_addr, tail_addr;
  logic [7:0]        seq_byte, tail_byte;
  logic              seq_par, tail_par, launch;
  sym_t              sym;
  logic [2:0]        tick;

  always_comb begin
    if (nbytes == '0) begin
      len_eff = LEN_W'(1);
    end else if (nbytes > LEN_W'(MAX_BYTES)) begin
      len_eff = LEN_W'(MAX_BYTES);
    end else begin
      len_eff = nbytes;
    end
    tail_addr = short_mode ? '0 : ADDR_W'(len_eff - LEN_W'(1));
  end

  card_enc_store #(.DEPTH(MAX_BYTES), .ADDR_W(ADDR_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && !busy), .wr_addr(wr_addr), .wr_data(wr_data), .wr_par(wr_par),
    .rd_addr_a(seq_addr), .rd_byte_a(seq_byte), .rd_par_a(seq_par),
    .rd_addr_b(tail_addr), .rd_byte_b(tail_byte), .rd_par_b(tail_par)
  );

  card_enc_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .coll_mode(coll_mode), .short_mode(short_mode), .par_sel(par_sel),
    .len_eff(len_eff), .rd_byte(seq_byte), .rd_par(seq_par), .rd_addr(seq_addr),
    .busy(busy), .launch(launch), .sym(sym), .tick(tick)
  );

  card_enc_dur #(.LEN_W(LEN_W), .DUR_W(DUR_W)) dur_i (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .coll_mode(coll_mode), .short_mode(short_mode), .par_sel(par_sel),
    .len_eff(len_eff), .tail_byte(tail_byte), .tail_par(tail_par),
    .duration(duration)
  );

  card_enc_shift shift_i (.sym(sym), .tick(tick), .mod_out(mod_out));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mod_out);

  a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(duration));

  a_r4_coll_no_zero_half: assert property (@(posedge clk) disable iff (!rst_n)
    (sym == SYM_COLL) |-> mod_out);

endmodule

// File: tb/card_resp_encoder_tb_top.sv
`timescale 1ns/1ps
module card_resp_encoder_tb_top;

  localparam int MAXB = 32;

  typedef struct packed {
    int nb; bit psel; bit coll; bit shrt; int seed;
  } case_t;

  localparam int NCASE = 9;
  localparam case_t CASES [NCASE] = '{
    '{nb: 1,  psel: 1'b0, coll: 1'b0, shrt: 1'b0, seed: 1},
    '{nb: 3,  psel: 1'b1, coll: 1'b0, shrt: 1'b0, seed: 2},
    '{nb: 8,  psel: 1'b0, coll: 1'b1, shrt: 1'b0, seed: 3},
    '{nb: 32, psel: 1'b1, coll: 1'b0, shrt: 1'b0, seed: 4},
    '{nb: 5,  psel: 1'b0, coll: 1'b0, shrt: 1'b1, seed: 5},
    '{nb: 2,  psel: 1'b1, coll: 1'b1, shrt: 1'b1, seed: 6},
    '{nb: 4,  psel: 1'b0, coll: 1'b0, shrt: 1'b0, seed: 7},
    '{nb: 0,  psel: 1'b1, coll: 1'b0, shrt: 1'b0, seed: 8},
    '{nb: 40, psel: 1'b0, coll: 1'b0, shrt: 1'b0, seed: 9}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_par = 1'b0;
  logic [5:0] nbytes = '0;
  logic par_sel = 1'b0, coll_mode = 1'b0, short_mode = 1'b0, start = 1'b0;
  logic mod_out, busy;
  logic [11:0] duration;

  card_resp_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_par(wr_par), .nbytes(nbytes), .par_sel(par_sel), .coll_mode(coll_mode),
    .short_mode(short_mode), .start(start), .mod_out(mod_out), .busy(busy),
    .duration(duration)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 1'b0;
  logic [7:0] mb [MAXB];
  logic       mp [MAXB];
  bit exp_bits [2400];
  int exp_len, exp_dur;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic load_all(int seed);
    for (int i = 0; i < MAXB; i++) begin
      @(negedge clk);
      mb[i] = 8'(seed * 53 + i * 29 + i * i * 7);
      mp[i] = 1'(((seed * 7 + i * 5) >> 1) & 1);
      wr_en = 1'b1; wr_addr = 5'(i); wr_data = mb[i]; wr_par = mp[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_sym(logic [7:0] p);
    for (int k = 7; k >= 0; k--) begin
      exp_bits[exp_len] = p[k];
      exp_len++;
    end
  endtask

  task automatic build_expected(int nb_in, bit psel, bit coll, bit shrt);
    int n;
    bit pb, lastb;
    n = (nb_in == 0) ? 1 : ((nb_in > MAXB) ? MAXB : nb_in);
    exp_len = 0;
    push_sym(8'h08);
    push_sym(8'hF0);
    lastb = 1'b0;
    if (shrt) begin
      for (int b = 0; b < 4; b++) begin
        push_sym(coll ? 8'hFF : (mb[0][b] ? 8'hF0 : 8'h0F));
        lastb = mb[0][b];
      end
      exp_dur = 40;
    end else begin
      for (int i = 0; i < n; i++) begin
        for (int b = 0; b < 8; b++) push_sym(coll ? 8'hFF : (mb[i][b] ? 8'hF0 : 8'h0F));
        pb = psel ? mp[i] : ~^mb[i];
        push_sym(coll ? 8'hFF : (pb ? 8'hF0 : 8'h0F));
        lastb = pb;
      end
      exp_dur = 8 * (9 * n + 1);
    end
    if (lastb && !coll) exp_dur = exp_dur - 4;
    push_sym(8'h00);
  endtask

  task automatic run_frame(case_t c, string tags, bit perturb);
    int cnt, mism, bad_at;
    build_expected(c.nb, c.psel, c.coll, c.shrt);
    @(negedge clk);
    nbytes = 6'(c.nb); par_sel = c.psel; coll_mode = c.coll; short_mode = c.shrt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0; mism = 0; bad_at = -1;
    while (busy && cnt < 2400) begin
      if (mod_out !== exp_bits[cnt]) begin
        mism++;
        if (bad_at < 0) bad_at = cnt;
      end
      if (perturb && cnt == 20) begin
        start = 1'b1; coll_mode = ~c.coll; par_sel = ~c.psel; short_mode = ~c.shrt;
        nbytes = 6'd7; wr_en = 1'b1; wr_addr = 5'd0; wr_data = ~mb[0]; wr_par = ~mp[0];
      end
      if (perturb && cnt == 21) begin
        start = 1'b0; wr_en = 1'b0;
      end
      cnt++;
      @(negedge clk);
    end
    chk(mism == 0, {tags, " stream"}, bad_at, -1);
    chk(cnt == exp_len, "R6 busy length", cnt, exp_len);
    chk(int'(duration) == exp_dur, "R7 duration", int'(duration), exp_dur);
    chk(mod_out == 1'b0, "R1 idle output", int'(mod_out), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mod_out == 1'b0 && busy == 1'b0, "R1 reset outputs", int'({busy, mod_out}), 0);
    chk(duration == 12'd0, "R1 reset duration", int'(duration), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 idle after reset", int'(busy), 0);

    for (int ci = 0; ci < NCASE; ci++) begin
      load_all(CASES[ci].seed);
      run_frame(CASES[ci], "R2 R3 R4 R5 R10", 1'b0);
    end

    // mid-frame start, option changes and writes must not disturb the frame
    load_all(11);
    run_frame('{nb: 3, psel: 1'b0, coll: 1'b0, shrt: 1'b0, seed: 11}, "R8 R11 perturbed", 1'b1);
    // the write attempted during that frame must have been dropped
    run_frame('{nb: 3, psel: 1'b0, coll: 1'b0, shrt: 1'b0, seed: 11}, "R9 write ignored", 1'b0);
    run_frame('{nb: 1, psel: 1'b1, coll: 1'b0, shrt: 1'b1, seed: 11}, "R9 R5 short after busy write", 1'b0);

    // reset during a frame returns to the quiet state
    @(negedge clk);
    nbytes = 6'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && mod_out == 1'b0, "R1 reset mid-frame", int'({busy, mod_out}), 0);
    chk(duration == 12'd0, "R1 reset clears duration", int'(duration), 0);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule